// File: doc/BRIEF.md
# Duty-Cycled Receive Link Sequencer

This block runs the receive side of a half-duplex near-field link whose supply cannot deliver much peak current. Most of the time it sits idle in a monitoring state with the receive front-end unpowered. A slow periodic tick wakes it. It then gates the front-end on, takes the analog chain through a three-phase startup, and listens for a beacon for a bounded number of cycles. If the beacon arrives, it waits a wakeup delay with the front-end off and then sends an acknowledgement pulse.

After that first acknowledgement the block loops over packets. It powers up and captures until the decoder reports capture-done, then powers down so the charge reservoir can recharge, and acknowledges. The length of the silence before the acknowledgement carries the message. One recharge interval of Tack cycles asks for the next packet. Two intervals, 2×Tack, ask the far end to resend the same packet after a decode error. The session ends when the receive FIFO reports full. The block also drives the comparator offset tuning bits for each session.

Top module: `link_seq_ctrl`

## Requirements
- R1: While reset is held and after it is released, every output is low and the block is in the monitoring state.
- R2: A tick on `wake_tick_i` seen in the monitoring state raises `fe_pwr_o` on that same clock edge. A tick at any other time has no effect. Beacon and capture-done inputs seen in the monitoring state have no effect.
- R3: After `fe_pwr_o` rises there is exactly one cycle with no startup strobe. Then `fe_cap_boost_o` is high for Lb cycles, `fe_bias_kick_o` for Lk cycles and `fe_cmfb_boost_o` for Lc cycles, in that order, with no gap and never two at once. A length of 0 acts as 1.
- R4: Once startup ends for the listen window, the block listens for N cycles, where N is the listen limit and 0 acts as 1. If no beacon is sampled in that window, `fe_pwr_o` falls exactly N edges after the edge that ended startup, and the block returns to monitoring.
- R5: A beacon sampled during the listen window turns the front-end off. `tx_ack_o` rises exactly W edges after that sample edge, where W is the wakeup delay and 0 acts as 1. `tx_ack_o` is never high while `fe_pwr_o` is high.
- R6: When an acknowledgement ends, the front-end restarts through the R3 sequence. `capture_o` rises on the edge that ends the last phase and stays high until `capture_done_i` is sampled. On that edge both `capture_o` and `fe_pwr_o` fall.
- R7: A capture-done sampled with `pkt_err_i` low and `fifo_full_i` low makes `tx_ack_o` rise exactly T edges later, where T is Tack and 0 acts as 1.
- R8: A capture-done sampled with `pkt_err_i` high makes `tx_ack_o` rise exactly 2T edges later, whatever `fifo_full_i` is.
- R9: A capture-done sampled with `pkt_err_i` low and `fifo_full_i` high sends no acknowledgement and returns the block to monitoring with the front-end off.
- R10: Each acknowledgement is high for exactly ACK_LEN cycles, and a new one never starts while one is in progress.
- R11: All timing settings and `cfg_tune_i` are latched on the tick that starts a session. Changes to those inputs during the session have no effect, and `cmp_tune_o` changes only on the cycle after such a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wake_tick_i | input | 1 | Periodic wakeup tick |
| beacon_i | input | 1 | Beacon detected |
| capture_done_i | input | 1 | Decoder finished the capture window |
| pkt_err_i | input | 1 | Captured bitstream mismatched, qualified by capture_done_i |
| fifo_full_i | input | 1 | Receive FIFO full, qualified by capture_done_i |
| cfg_tack_i | input | CNT_W | Recharge interval Tack in cycles |
| cfg_wake_dly_i | input | CNT_W | Delay from beacon to first acknowledgement |
| cfg_listen_i | input | CNT_W | Listen window length in cycles |
| cfg_boost_len_i | input | CNT_W | Coupling-capacitor boost phase length |
| cfg_kick_len_i | input | CNT_W | Bias kick-start phase length |
| cfg_cmfb_len_i | input | CNT_W | Common-mode-feedback boost phase length |
| cfg_tune_i | input | TUNE_W | Comparator offset tuning for the next session |
| fe_pwr_o | output | 1 | Front-end power gate enable |
| fe_cap_boost_o | output | 1 | Coupling-capacitor boost strobe |
| fe_bias_kick_o | output | 1 | Bias kick-start strobe |
| fe_cmfb_boost_o | output | 1 | Common-mode-feedback boost strobe |
| tx_ack_o | output | 1 | Acknowledgement pulse to the transmitter |
| capture_o | output | 1 | Capture request to the decoder |
| cmp_tune_o | output | TUNE_W | Comparator offset tuning bits |

## Verification
The assertions check the structural rules on every cycle:
- the startup strobes never overlap, and boost follows a cycle of bare power;
- the acknowledgement is never sent while the front-end is powered, and each pulse has exactly the fixed width;
- a capture request is only raised with the front-end powered and idle;
- the tuning bits move only after a tick seen while idle.

Only the bench scenarios can show the exact delays. These are the listen timeout, the wakeup delay, and the T versus 2T acknowledgement spacing, swept over several Tack values. The scenarios also cover the FIFO-full stop, error taking precedence over FIFO-full, and configuration and ticks being ignored mid-session.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

    typedef enum logic [2:0] {
        MS_MONITOR,
        MS_SU_LISTEN,
        MS_LISTEN,
        MS_WAKE_WAIT,
        MS_ACK,
        MS_SU_CAPTURE,
        MS_CAPTURE,
        MS_RECHARGE
    } main_st_e;

    typedef enum logic [2:0] {
        SU_IDLE,
        SU_GATE,
        SU_BOOST,
        SU_KICK,
        SU_CMFB
    } su_st_e;

endpackage

// File: rtl/link_startup_seq.sv
module link_startup_seq
    import link_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CNT_W-1:0] boost_len_i,
    input  logic [CNT_W-1:0] kick_len_i,
    input  logic [CNT_W-1:0] cmfb_len_i,
    output logic             boost_o,
    output logic             kick_o,
    output logic             cmfb_o,
    output logic             done_o
);

    typedef struct packed {
        su_st_e           st;
        logic [CNT_W-1:0] cnt;
    } su_t;

    su_t s_d, s_q;

    function automatic logic [CNT_W-1:0] first_cnt(input logic [CNT_W-1:0] len);
        return (len == '0) ? '0 : len - CNT_W'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SU_IDLE: if (start_i) s_d.st = SU_GATE;
            SU_GATE: begin
                s_d.st  = SU_BOOST;
                s_d.cnt = first_cnt(boost_len_i);
            end
            SU_BOOST: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = SU_KICK;
                    s_d.cnt = first_cnt(kick_len_i);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            SU_KICK: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = SU_CMFB;
                    s_d.cnt = first_cnt(cmfb_len_i);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            SU_CMFB: begin
                if (s_q.cnt == '0) s_d.st = SU_IDLE;
                else               s_d.cnt = s_q.cnt - CNT_W'(1);
            end
            default: s_d.st = SU_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.st  <= SU_IDLE;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign boost_o = (s_q.st == SU_BOOST);
    assign kick_o  = (s_q.st == SU_KICK);
    assign cmfb_o  = (s_q.st == SU_CMFB);
    assign done_o  = (s_q.st == SU_CMFB) && (s_q.cnt == '0);

endmodule

// File: rtl/link_delay_timer.sv
module link_delay_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             twice_i,
    output logic             done_o
);

    typedef struct packed {
        logic             act;
        logic             again;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    logic last_tick;
    assign last_tick = t_q.act && (t_q.cnt <= CNT_W'(1));

    always_comb begin
        t_d = t_q;
        if (load_i) begin
            t_d.act   = 1'b1;
            t_d.again = twice_i;
            t_d.len   = len_i;
            t_d.cnt   = len_i;
        end else if (t_q.act) begin
            if (last_tick) begin
                if (t_q.again) begin
                    t_d.again = 1'b0;
                    t_d.cnt   = t_q.len;
                end else begin
                    t_d.act = 1'b0;
                end
            end else begin
                t_d.cnt = t_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign done_o = last_tick && !t_q.again;

endmodule

// File: rtl/link_ack_pulse.sv
module link_ack_pulse #(
    parameter int ACK_LEN = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic pulse_o
);

    localparam int AW = $clog2(ACK_LEN + 1);

    logic [AW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0)  cnt_d = cnt_q - AW'(1);
        else if (start_i) cnt_d = AW'(ACK_LEN);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign pulse_o = (cnt_q != '0);

endmodule

// File: rtl/link_seq_ctrl.sv
module link_seq_ctrl
    import link_seq_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int TUNE_W  = 4,
    parameter int ACK_LEN = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wake_tick_i,
    input  logic              beacon_i,
    input  logic              capture_done_i,
    input  logic              pkt_err_i,
    input  logic              fifo_full_i,
    input  logic [CNT_W-1:0]  cfg_tack_i,
    input  logic [CNT_W-1:0]  cfg_wake_dly_i,
    input  logic [CNT_W-1:0]  cfg_listen_i,
    input  logic [CNT_W-1:0]  cfg_boost_len_i,
    input  logic [CNT_W-1:0]  cfg_kick_len_i,
    input  logic [CNT_W-1:0]  cfg_cmfb_len_i,
    input  logic [TUNE_W-1:0] cfg_tune_i,
    output logic              fe_pwr_o,
    output logic              fe_cap_boost_o,
    output logic              fe_bias_kick_o,
    output logic              fe_cmfb_boost_o,
    output logic              tx_ack_o,
    output logic              capture_o,
    output logic [TUNE_W-1:0] cmp_tune_o
);

    typedef struct packed {
        logic [CNT_W-1:0] tack;
        logic [CNT_W-1:0] wake;
        logic [CNT_W-1:0] listen;
        logic [CNT_W-1:0] boost;
        logic [CNT_W-1:0] kick;
        logic [CNT_W-1:0] cmfb;
    } sess_cfg_t;

    typedef struct packed {
        main_st_e          st;
        sess_cfg_t         cfg;
        logic [TUNE_W-1:0] tune;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic             su_start, su_done;
    logic             tmr_load, tmr_twice, tmr_done;
    logic [CNT_W-1:0] tmr_len;
    logic             ack_start, ack_busy;

    always_comb begin
        c_d       = c_q;
        su_start  = 1'b0;
        tmr_load  = 1'b0;
        tmr_twice = 1'b0;
        tmr_len   = '0;
        ack_start = 1'b0;
        unique case (c_q.st)
            MS_MONITOR: begin
                if (wake_tick_i) begin
                    c_d.cfg.tack   = cfg_tack_i;
                    c_d.cfg.wake   = cfg_wake_dly_i;
                    c_d.cfg.listen = cfg_listen_i;
                    c_d.cfg.boost  = cfg_boost_len_i;
                    c_d.cfg.kick   = cfg_kick_len_i;
                    c_d.cfg.cmfb   = cfg_cmfb_len_i;
                    c_d.tune       = cfg_tune_i;
                    c_d.st         = MS_SU_LISTEN;
                    su_start       = 1'b1;
                end
            end
            MS_SU_LISTEN: begin
                if (su_done) begin
                    c_d.st   = MS_LISTEN;
                    tmr_load = 1'b1;
                    tmr_len  = c_q.cfg.listen;
                end
            end
            MS_LISTEN: begin
                if (beacon_i) begin
                    c_d.st   = MS_WAKE_WAIT;
                    tmr_load = 1'b1;
                    tmr_len  = c_q.cfg.wake;
                end else if (tmr_done) begin
                    c_d.st = MS_MONITOR;
                end
            end
            MS_WAKE_WAIT, MS_RECHARGE: begin
                if (tmr_done) begin
                    c_d.st    = MS_ACK;
                    ack_start = 1'b1;
                end
            end
            MS_ACK: begin
                if (!ack_busy) begin
                    c_d.st   = MS_SU_CAPTURE;
                    su_start = 1'b1;
                end
            end
            MS_SU_CAPTURE: begin
                if (su_done) c_d.st = MS_CAPTURE;
            end
            MS_CAPTURE: begin
                if (capture_done_i) begin
                    if (pkt_err_i) begin
                        c_d.st    = MS_RECHARGE;
                        tmr_load  = 1'b1;
                        tmr_len   = c_q.cfg.tack;
                        tmr_twice = 1'b1;
                    end else if (fifo_full_i) begin
                        c_d.st = MS_MONITOR;
                    end else begin
                        c_d.st   = MS_RECHARGE;
                        tmr_load = 1'b1;
                        tmr_len  = c_q.cfg.tack;
                    end
                end
            end
            default: c_d.st = MS_MONITOR;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q.st   <= MS_MONITOR;
            c_q.cfg  <= '0;
            c_q.tune <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    link_startup_seq #(.CNT_W(CNT_W)) su_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (su_start),
        .boost_len_i (c_q.cfg.boost),
        .kick_len_i  (c_q.cfg.kick),
        .cmfb_len_i  (c_q.cfg.cmfb),
        .boost_o     (fe_cap_boost_o),
        .kick_o      (fe_bias_kick_o),
        .cmfb_o      (fe_cmfb_boost_o),
        .done_o      (su_done)
    );

    link_delay_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (tmr_load),
        .len_i   (tmr_len),
        .twice_i (tmr_twice),
        .done_o  (tmr_done)
    );

    link_ack_pulse #(.ACK_LEN(ACK_LEN)) ack_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (ack_start),
        .pulse_o (ack_busy)
    );

    assign tx_ack_o   = ack_busy;
    assign fe_pwr_o   = (c_q.st == MS_SU_LISTEN) || (c_q.st == MS_LISTEN) ||
                        (c_q.st == MS_SU_CAPTURE) || (c_q.st == MS_CAPTURE);
    assign capture_o  = (c_q.st == MS_CAPTURE);
    assign cmp_tune_o = c_q.tune;

endmodule

// File: rtl/link_seq_ctrl_chk.sv
module link_seq_ctrl_chk #(
    parameter int TUNE_W  = 4,
    parameter int ACK_LEN = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wake_tick_i,
    input logic              fe_pwr_o,
    input logic              fe_cap_boost_o,
    input logic              fe_bias_kick_o,
    input logic              fe_cmfb_boost_o,
    input logic              tx_ack_o,
    input logic              capture_o,
    input logic [TUNE_W-1:0] cmp_tune_o
);

    localparam int CW = $clog2(ACK_LEN + 2);

    logic [CW-1:0] ack_run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       ack_run_q <= '0;
        else if (tx_ack_o) ack_run_q <= ack_run_q + CW'(1);
        else               ack_run_q <= '0;
    end

    // R3
    strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({fe_cap_boost_o, fe_bias_kick_o, fe_cmfb_boost_o}));

    // R3
    gate_before_boost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fe_cap_boost_o) |-> $past(fe_pwr_o) && !$past(fe_cap_boost_o) &&
                                  !$past(fe_bias_kick_o) && !$past(fe_cmfb_boost_o));

    // R3
    strobe_needs_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fe_cap_boost_o || fe_bias_kick_o || fe_cmfb_boost_o) |-> fe_pwr_o);

    // R5
    ack_power_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_ack_o |-> !fe_pwr_o);

    // R6
    capture_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capture_o |-> fe_pwr_o && !fe_cap_boost_o && !fe_bias_kick_o && !fe_cmfb_boost_o);

    // R10
    ack_no_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_ack_o |-> (ack_run_q < CW'(ACK_LEN)));

    // R10
    ack_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(tx_ack_o) |-> (ack_run_q == CW'(ACK_LEN)));

    // R11
    tune_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cmp_tune_o) |-> $past(wake_tick_i) && !$past(fe_pwr_o));

endmodule

bind link_seq_ctrl link_seq_ctrl_chk #(.TUNE_W(TUNE_W), .ACK_LEN(ACK_LEN)) chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wake_tick_i     (wake_tick_i),
    .fe_pwr_o        (fe_pwr_o),
    .fe_cap_boost_o  (fe_cap_boost_o),
    .fe_bias_kick_o  (fe_bias_kick_o),
    .fe_cmfb_boost_o (fe_cmfb_boost_o),
    .tx_ack_o        (tx_ack_o),
    .capture_o       (capture_o),
    .cmp_tune_o      (cmp_tune_o)
);

// File: tb/link_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_seq_ctrl_tb_top;

    localparam int CW = 8;
    localparam int TW = 4;
    localparam int AL = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wake_tick, beacon, cap_done, pkt_err, fifo_full;
    logic [CW-1:0] tack, wdly, lsn, lb, lk, lc;
    logic [TW-1:0] tune;
    logic          fe_pwr, s_boost, s_kick, s_cmfb, tx_ack, capture;
    logic [TW-1:0] tune_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    link_seq_ctrl #(.CNT_W(CW), .TUNE_W(TW), .ACK_LEN(AL)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wake_tick_i(wake_tick), .beacon_i(beacon),
        .capture_done_i(cap_done), .pkt_err_i(pkt_err), .fifo_full_i(fifo_full),
        .cfg_tack_i(tack), .cfg_wake_dly_i(wdly), .cfg_listen_i(lsn),
        .cfg_boost_len_i(lb), .cfg_kick_len_i(lk), .cfg_cmfb_len_i(lc),
        .cfg_tune_i(tune), .fe_pwr_o(fe_pwr), .fe_cap_boost_o(s_boost),
        .fe_bias_kick_o(s_kick), .fe_cmfb_boost_o(s_cmfb), .tx_ack_o(tx_ack),
        .capture_o(capture), .cmp_tune_o(tune_o)
    );

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
        end
    end

    task automatic tick();
        wake_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wake_tick = 1'b0;
    endtask

    // R3: waits for power, then checks gate cycle, phase order and lengths
    task automatic check_startup(input int b, input int k, input int c, input bit to_cap);
        int g = 0;
        int cnt[3];
        int last = 0;
        int idx;
        logic [2:0] v;
        cnt = '{0, 0, 0};
        while (!fe_pwr && g < 1000) begin
            @(negedge clk);
            g++;
        end
        v = {s_cmfb, s_kick, s_boost};
        chk(fe_pwr && v == 3'b000, "R3 gate cycle", int'(v), 0);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            v = {s_cmfb, s_kick, s_boost};
            if (v == 3'b000) break;
            idx = (v == 3'b001) ? 0 : (v == 3'b010) ? 1 : (v == 3'b100) ? 2 : 3;
            if (idx == 3 || idx < last) chk(0, "R3 phase order", int'(v), last);
            else begin
                last = idx;
                cnt[idx]++;
            end
        end
        chk(cnt[0] == eff(b), "R3 boost length", cnt[0], eff(b));
        chk(cnt[1] == eff(k), "R3 kick length", cnt[1], eff(k));
        chk(cnt[2] == eff(c), "R3 cmfb length", cnt[2], eff(c));
        if (to_cap) chk(capture && fe_pwr, "R6 capture after startup", int'(capture), 1);
        else        chk(fe_pwr && !capture, "R4 listening after startup", int'(fe_pwr), 1);
    endtask

    // counts edges after the sample edge until tx_ack_o is seen high
    task automatic edges_to_ack(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!tx_ack && n < 600);
    endtask

    // R10
    task automatic ack_width();
        int w = 1;
        @(negedge clk);
        while (tx_ack && w < 100) begin
            w++;
            @(negedge clk);
        end
        chk(w == AL, "R10 ack width", w, AL);
    endtask

    task automatic packet(input bit err, input bit full, input int t, input bit disturb, input int tn);
        int n;
        bit seen;
        check_startup(1, 1, 1, 1);
        repeat (2) @(negedge clk);
        chk(capture == 1'b1, "R6 capture held", int'(capture), 1);
        if (disturb) begin
            tack = CW'(t + 7);
            tune = ~TW'(tn);
            tick();
            chk(capture && fe_pwr && !s_boost, "R2 tick ignored mid-session", int'(capture), 1);
        end
        cap_done  = 1'b1;
        pkt_err   = err;
        fifo_full = full;
        @(posedge clk);
        @(negedge clk);
        cap_done  = 1'b0;
        pkt_err   = 1'b0;
        fifo_full = 1'b0;
        chk(!capture && !fe_pwr, "R6 power off after capture-done", int'(fe_pwr), 0);
        if (full && !err) begin
            seen = 0;
            for (int i = 0; i < 3 * eff(t) + 20; i++) begin
                @(negedge clk);
                if (tx_ack || fe_pwr) seen = 1;
            end
            chk(!seen, "R9 no ack after fifo full", int'(seen), 0);
        end else begin
            edges_to_ack(n);
            if (err) chk(n == 2 * eff(t), "R8 retry delay", n, 2 * eff(t));
            else     chk(n == eff(t), "R7 next delay", n, eff(t));
            chk(tune_o == TW'(tn), "R11 tune latched", int'(tune_o), tn);
            ack_width();
        end
    endtask

    initial begin
        int n;
        wake_tick = 0; beacon = 0; cap_done = 0; pkt_err = 0; fifo_full = 0;
        tack = 2; wdly = 2; lsn = 3; lb = 1; lk = 1; lc = 1; tune = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({fe_pwr, s_boost, s_kick, s_cmfb, tx_ack, capture} == 6'b0 && tune_o == 0,
            "R1 reset outputs", int'({fe_pwr, tx_ack, capture}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!fe_pwr && !tx_ack && !capture, "R1 idle after reset", int'(fe_pwr), 0);

        // R2: beacon and capture-done ignored while monitoring
        beacon = 1; cap_done = 1;
        repeat (4) @(negedge clk);
        beacon = 0; cap_done = 0;
        repeat (2) @(negedge clk);
        chk(!fe_pwr && !tx_ack && !capture, "R2 monitor ignores inputs", int'(fe_pwr), 0);

        // R3/R4 sweep of phase lengths and listen limits
        for (int b = 0; b < 3; b++) begin
            for (int k = 1; k < 3; k++) begin
                lb = CW'(b); lk = CW'(k); lc = CW'(b + 1); lsn = CW'(b + k - 1);
                tick();
                chk(fe_pwr == 1'b1, "R2 tick powers up", int'(fe_pwr), 1);
                check_startup(b, k, b + 1, 0);
                n = 0;
                do begin
                    @(posedge clk);
                    n++;
                    @(negedge clk);
                end while (fe_pwr && n < 500);
                chk(n == eff(b + k - 1), "R4 listen timeout", n, eff(b + k - 1));
                chk(!tx_ack && !capture, "R4 back to monitor", int'(tx_ack), 0);
            end
        end

        // R5..R11 full sessions over a sweep of Tack
        for (int t = 0; t < 5; t++) begin
            tack = CW'(t); wdly = CW'(t + 1); lsn = 4; lb = 1; lk = 1; lc = 1;
            tune = TW'(t + 3);
            tick();
            check_startup(1, 1, 1, 0);
            tune = TW'(0);
            wdly = CW'(20);
            beacon = 1'b1;
            @(posedge clk);
            @(negedge clk);
            beacon = 1'b0;
            chk(!fe_pwr, "R5 power off during wakeup wait", int'(fe_pwr), 0);
            edges_to_ack(n);
            chk(n == t + 1, "R5 wakeup delay", n, t + 1);
            chk(!fe_pwr, "R5 ack with power off", int'(fe_pwr), 0);
            chk(tune_o == TW'(t + 3), "R11 tune output", int'(tune_o), t + 3);
            ack_width();
            packet(0, 0, t, 0, t + 3);
            packet(1, 0, t, 1, t + 3);
            packet(1, 1, t, 0, t + 3);
            packet(0, 0, t, 0, t + 3);
            packet(0, 1, t, 0, t + 3);
        end

        repeat (5) @(negedge clk);
        summary();
    end

endmodule